// File: doc/BRIEF.md
# Link Error Counter and Alarm Monitor

This block sits behind the line decoder of a serial-link receiver and keeps track of how healthy the link is. The decoder sends it one strobe per symbol time for three kinds of fault: an uncorrectable (detected) error, an error that the decoder corrected, and a mismatch seen while a pseudo-random test pattern is running. It also sends a level that says whether it has acquired alignment. The monitor keeps its own lock state and counts faults into saturating 8-bit counters. It raises an active-low alarm when a counter goes above a programmable limit, or as soon as a test-pattern error shows up in test mode.

Software reaches the counters and the settings through a simple read/write register port. Reading a counter returns its value and clears it. Read data appears one cycle after the read strobe. An optional self-clearing mode wipes the counters a fixed number of cycles after the alarm drops, so that the alarm behaves as a pulse. If uncorrectable errors grow too dense over a sliding window of recent symbols, the monitor gives up lock, freezes its counters and asks the decoder to re-acquire alignment.

Top module: `link_err_mon`

## Requirements
- R1: After reset, alarm_n_o is 1, lock_o and relock_o are 0, and the registers at 0x10, 0x12, 0x13 and 0x08 read 0. Both threshold registers (0x20 for detected, 0x21 for corrected) read DET_THR_RST and CORR_THR_RST (default 15).
- R2: While lock_o is 1 and prbs_mode_i is 0, each det_err_i strobe adds one to the detected counter (read at 0x10), and each corr_err_i strobe adds one to the corrected counter (read at 0x12). Both counters stop at 255 and never wrap.
- R3: A read strobe returns the addressed value on reg_rdata_o in the next cycle and clears that counter. If a strobe for the same counter arrives in the same cycle as the read, the counter afterwards holds 1.
- R4: In normal mode, alarm_n_o goes to 0 one cycle after the detected counter becomes greater than the value at 0x20, or after the corrected counter becomes greater than the value at 0x21. A count equal to its threshold does not raise the alarm.
- R5: In normal mode, alarm_n_o returns to 1 one cycle after both counters have been cleared, whatever the cause of the clear.
- R6: When lock_i is 1 while the monitor is unlocked, lock_o rises in the next cycle. All three counters are zero from that cycle on.
- R7: While lock_o is 0, error strobes leave all counters unchanged.
- R8: While prbs_mode_i is 1, the detected and corrected counters are held at 0. prbs_err_i strobes are counted into a saturating counter at 0x13, which is cleared on read and cleared when test mode is entered. alarm_n_o goes to 0 one cycle after that counter first becomes non-zero.
- R9: Bit 2 of register 0x08 enables self-clearing. When it is enabled and the alarm is low in normal mode, the counters clear AUTO_CLR_CYC cycles after the alarm fell, so the alarm stays low for AUTO_CLR_CYC+1 cycles. Self-clearing never acts while prbs_mode_i is 1, and it is off when bit 2 is 0.
- R10: When the locked monitor has seen WIN_LEN/4 det_err_i strobes within the last WIN_LEN cycles, lock_o falls and relock_o rises in the next cycle. The strobe that triggers this is still counted.
- R11: After a density loss the monitor stays unlocked, with relock_o at 1, while lock_i remains 1. Once lock_i has been 0 for a cycle, relock_o drops, and the monitor relocks on the next lock_i high.
- R12: Writes to 0x08, 0x20 and 0x21 read back the written value (for 0x08, only bit 2 is kept). Addresses that are not assigned read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one symbol per cycle |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | Decoder reports alignment acquired |
| det_err_i | input | 1 | Uncorrectable symbol error strobe |
| corr_err_i | input | 1 | Corrected error strobe |
| prbs_err_i | input | 1 | Test-pattern mismatch strobe |
| prbs_mode_i | input | 1 | Test-pattern mode select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data, valid the cycle after reg_rd_i |
| alarm_n_o | output | 1 | Active-low error alarm |
| lock_o | output | 1 | Monitor lock status |
| relock_o | output | 1 | Request to the decoder to re-acquire after a density loss |

## Verification
The bench sweeps error counts around each threshold. A monitor that compares with greater-or-equal, or that wraps past 255, would give an alarm or a count that is off by one. It collides a strobe with a read of the same counter and expects a count of 1; a design that gives the clear priority would lose that error. It drives uncorrectable errors spaced five and six cycles apart against the sixteen-symbol window, so that a window that is one slot too short or too long would drop lock wrongly or not at all. It measures how long the alarm stays low under self-clearing, and checks that self-clearing stays idle in test mode, where a design that forgot the mode check would wipe the test-pattern alarm.

// File: rtl/link_err_pkg.sv
package link_err_pkg;

  typedef enum logic [1:0] {
    LS_UNLOCKED = 2'd0,
    LS_LOCKED   = 2'd1,
    LS_RELOCK   = 2'd2
  } lock_st_e;

  localparam logic [7:0] A_CTRL     = 8'h08;
  localparam logic [7:0] A_DET      = 8'h10;
  localparam logic [7:0] A_CORR     = 8'h12;
  localparam logic [7:0] A_PRBS     = 8'h13;
  localparam logic [7:0] A_DET_THR  = 8'h20;
  localparam logic [7:0] A_CORR_THR = 8'h21;

  localparam int ACLR_BIT = 2;

  localparam int CI_DET  = 0;
  localparam int CI_CORR = 1;
  localparam int CI_PRBS = 2;
  localparam int N_CNT   = 3;

endpackage

// File: rtl/lerr_sat_cnt.sv
module lerr_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         rd_clr_i,
  input  logic         hold_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o <= '0;
    end else if (rd_clr_i) begin
      // a strobe landing together with the read is kept
      cnt_o <= (inc_i && !hold_i) ? ONE : '0;
    end else if (!hold_i && inc_i && cnt_o != MAXV) begin
      cnt_o <= cnt_o + ONE;
    end
  end

endmodule

// File: rtl/lerr_density.sv
module lerr_density #(
  parameter int WIN_LEN = 16,
  localparam int CW     = $clog2(WIN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          err_i,
  output logic          trip_o,
  output logic [CW-1:0] cnt_o
);

  localparam int THR = WIN_LEN / 4;

  logic [WIN_LEN-1:0] hist_q;
  logic [CW-1:0]      cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_o + CW'(err_i) - CW'(hist_q[WIN_LEN-1]);
    trip_o  = en_i && (cnt_nxt >= CW'(THR));
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      hist_q <= '0;
      cnt_o  <= '0;
    end else begin
      hist_q <= {hist_q[WIN_LEN-2:0], err_i};
      cnt_o  <= cnt_nxt;
    end
  end

endmodule

// File: rtl/lerr_regs.sv
module lerr_regs
  import link_err_pkg::*;
#(
  parameter int           W            = 8,
  parameter logic [W-1:0] DET_THR_RST  = 15,
  parameter logic [W-1:0] CORR_THR_RST = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [7:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] det_cnt_i,
  input  logic [W-1:0] corr_cnt_i,
  input  logic [W-1:0] prbs_cnt_i,
  output logic         aclr_en_o,
  output logic [W-1:0] det_thr_o,
  output logic [W-1:0] corr_thr_o,
  output logic [W-1:0] rdata_o
);

  logic [W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      aclr_en_o  <= 1'b0;
      det_thr_o  <= DET_THR_RST;
      corr_thr_o <= CORR_THR_RST;
    end else if (wr_i) begin
      case (addr_i)
        A_CTRL:     aclr_en_o  <= wdata_i[ACLR_BIT];
        A_DET_THR:  det_thr_o  <= wdata_i;
        A_CORR_THR: corr_thr_o <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_CTRL:     rd_mux[ACLR_BIT] = aclr_en_o;
      A_DET:      rd_mux = det_cnt_i;
      A_CORR:     rd_mux = corr_cnt_i;
      A_PRBS:     rd_mux = prbs_cnt_i;
      A_DET_THR:  rd_mux = det_thr_o;
      A_CORR_THR: rd_mux = corr_thr_o;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      rdata_o <= rd_mux;
    end
  end

endmodule

// File: rtl/link_err_mon.sv
module link_err_mon
  import link_err_pkg::*;
#(
  parameter int                CNT_W        = 8,
  parameter int                WIN_LEN      = 16,
  parameter int                AUTO_CLR_CYC = 250,
  parameter logic [CNT_W-1:0]  DET_THR_RST  = 15,
  parameter logic [CNT_W-1:0]  CORR_THR_RST = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_i,
  input  logic             det_err_i,
  input  logic             corr_err_i,
  input  logic             prbs_err_i,
  input  logic             prbs_mode_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [7:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic             alarm_n_o,
  output logic             lock_o,
  output logic             relock_o
);

  localparam int TW = $clog2(AUTO_CLR_CYC + 1);
  localparam int WW = $clog2(WIN_LEN + 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(AUTO_CLR_CYC - 1);

  lock_st_e state_q, state_d;
  logic     locked, acq, trip;
  logic     prbs_q, prbs_rise;
  logic     aclr_en, aclr_run, aclr_pulse;
  logic [TW-1:0] tmr_q;
  logic [WW-1:0] win_cnt;
  logic [CNT_W-1:0] det_thr, corr_thr;
  logic [CNT_W-1:0] det_cnt, corr_cnt, prbs_cnt;
  logic rd_det, rd_corr, rd_prbs;
  logic alarm_cond;

  logic [N_CNT-1:0] c_clr, c_rd, c_hold, c_inc;
  logic [CNT_W-1:0] c_val [N_CNT];

  // lock tracking
  assign locked = (state_q == LS_LOCKED);
  assign acq    = (state_q == LS_UNLOCKED) && lock_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      LS_UNLOCKED: if (lock_i) state_d = LS_LOCKED;
      LS_LOCKED: begin
        if (!lock_i)   state_d = LS_UNLOCKED;
        else if (trip) state_d = LS_RELOCK;
      end
      LS_RELOCK:   if (!lock_i) state_d = LS_UNLOCKED;
      default:     state_d = LS_UNLOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LS_UNLOCKED;
      prbs_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      prbs_q  <= prbs_mode_i;
    end
  end

  assign lock_o    = locked;
  assign relock_o  = (state_q == LS_RELOCK);
  assign prbs_rise = prbs_mode_i && !prbs_q;

  lerr_density #(.WIN_LEN(WIN_LEN)) dens_i (
    .clk    (clk),
    .rst    (rst),
    .en_i   (locked),
    .err_i  (det_err_i),
    .trip_o (trip),
    .cnt_o  (win_cnt)
  );

  // counter controls
  assign rd_det  = reg_rd_i && (reg_addr_i == A_DET);
  assign rd_corr = reg_rd_i && (reg_addr_i == A_CORR);
  assign rd_prbs = reg_rd_i && (reg_addr_i == A_PRBS);

  always_comb begin
    c_clr[CI_DET]   = acq || prbs_mode_i || aclr_pulse;
    c_clr[CI_CORR]  = acq || prbs_mode_i || aclr_pulse;
    c_clr[CI_PRBS]  = acq || prbs_rise;
    c_rd[CI_DET]    = rd_det;
    c_rd[CI_CORR]   = rd_corr;
    c_rd[CI_PRBS]   = rd_prbs;
    c_hold[CI_DET]  = !locked;
    c_hold[CI_CORR] = !locked;
    c_hold[CI_PRBS] = !locked || !prbs_mode_i;
    c_inc[CI_DET]   = det_err_i;
    c_inc[CI_CORR]  = corr_err_i;
    c_inc[CI_PRBS]  = prbs_err_i;
  end

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
    lerr_sat_cnt #(.W(CNT_W)) cnt_i (
      .clk      (clk),
      .rst      (rst),
      .clr_i    (c_clr[gi]),
      .rd_clr_i (c_rd[gi]),
      .hold_i   (c_hold[gi]),
      .inc_i    (c_inc[gi]),
      .cnt_o    (c_val[gi])
    );
  end

  assign det_cnt  = c_val[CI_DET];
  assign corr_cnt = c_val[CI_CORR];
  assign prbs_cnt = c_val[CI_PRBS];

  lerr_regs #(
    .W            (CNT_W),
    .DET_THR_RST  (DET_THR_RST),
    .CORR_THR_RST (CORR_THR_RST)
  ) regs_i (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .det_cnt_i  (det_cnt),
    .corr_cnt_i (corr_cnt),
    .prbs_cnt_i (prbs_cnt),
    .aclr_en_o  (aclr_en),
    .det_thr_o  (det_thr),
    .corr_thr_o (corr_thr),
    .rdata_o    (reg_rdata_o)
  );

  // alarm, registered from the counter state
  always_comb begin
    if (prbs_mode_i) alarm_cond = !prbs_rise && (prbs_cnt != '0);
    else             alarm_cond = (det_cnt > det_thr) || (corr_cnt > corr_thr);
  end

  always_ff @(posedge clk) begin
    if (rst) alarm_n_o <= 1'b1;
    else     alarm_n_o <= !alarm_cond;
  end

  // self-clearing timer, runs while the alarm is low
  assign aclr_run   = !alarm_n_o && aclr_en && !prbs_mode_i;
  assign aclr_pulse = aclr_run && (tmr_q == TMR_LAST);

  always_ff @(posedge clk) begin
    if (rst || !aclr_run)   tmr_q <= '0;
    else if (aclr_pulse)    tmr_q <= '0;
    else                    tmr_q <= tmr_q + 1'b1;
  end

endmodule

// File: rtl/link_err_mon_chk.sv
module link_err_mon_chk #(
  parameter int CNT_W   = 8,
  parameter int WIN_LEN = 16,
  localparam int WW     = $clog2(WIN_LEN + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             lock_o,
  input logic             prbs_mode_i,
  input logic             alarm_n_o,
  input logic             acq,
  input logic             aclr_pulse,
  input logic             rd_det,
  input logic [CNT_W-1:0] det_cnt,
  input logic [CNT_W-1:0] corr_cnt,
  input logic [CNT_W-1:0] prbs_cnt,
  input logic [WW-1:0]    win_cnt
);

  localparam logic [CNT_W-1:0] MAXV = '1;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (lock_o && !prbs_mode_i && !rd_det && !aclr_pulse && det_cnt == MAXV) |=> det_cnt == MAXV); // R2

  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (!prbs_mode_i && det_cnt == '0 && corr_cnt == '0) |=> alarm_n_o); // R5

  AST_ACQ_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> (det_cnt == '0 && corr_cnt == '0 && prbs_cnt == '0)); // R6

  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!lock_o && !acq && !rd_det && !prbs_mode_i && !aclr_pulse) |=> $stable(det_cnt)); // R7

  AST_PRBS_HOLD: assert property (@(posedge clk) disable iff (rst)
    prbs_mode_i |=> (det_cnt == '0 && corr_cnt == '0)); // R8

  AST_DENSE_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> (win_cnt < WW'(WIN_LEN / 4))); // R10

endmodule

bind link_err_mon link_err_mon_chk #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .lock_o      (lock_o),
  .prbs_mode_i (prbs_mode_i),
  .alarm_n_o   (alarm_n_o),
  .acq         (acq),
  .aclr_pulse  (aclr_pulse),
  .rd_det      (rd_det),
  .det_cnt     (det_cnt),
  .corr_cnt    (corr_cnt),
  .prbs_cnt    (prbs_cnt),
  .win_cnt     (win_cnt)
);

// File: tb/link_err_mon_tb_top.sv
module link_err_mon_tb_top;

  localparam int ACLR = 250;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lock_i = 1'b0;
  logic       det_err = 1'b0;
  logic       corr_err = 1'b0;
  logic       prbs_err = 1'b0;
  logic       prbs_mode = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       alarm_n, lock_o, relock_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  link_err_mon dut_i (
    .clk         (clk),
    .rst         (rst),
    .lock_i      (lock_i),
    .det_err_i   (det_err),
    .corr_err_i  (corr_err),
    .prbs_err_i  (prbs_err),
    .prbs_mode_i (prbs_mode),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .alarm_n_o   (alarm_n),
    .lock_o      (lock_o),
    .relock_o    (relock_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    reg_addr = a; reg_rd = 1'b1;
    tick(1);
    reg_rd = 1'b0;
    d = int'(reg_rdata);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic det_burst(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      det_err = 1'b1; tick(1); det_err = 1'b0; tick(gap - 1);
    end
  endtask

  task automatic corr_burst(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      corr_err = 1'b1; tick(1); corr_err = 1'b0; tick(gap - 1);
    end
  endtask

  task automatic prbs_burst(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      prbs_err = 1'b1; tick(1); prbs_err = 1'b0; tick(gap - 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int d;
    int low;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    check("R1 alarm_n", int'(alarm_n), 1);
    check("R1 lock_o", int'(lock_o), 0);
    check("R1 relock_o", int'(relock_o), 0);
    rd(8'h10, d); check("R1 det", d, 0);
    rd(8'h12, d); check("R1 corr", d, 0);
    rd(8'h13, d); check("R1 prbs", d, 0);
    rd(8'h08, d); check("R1 ctrl", d, 0);
    rd(8'h20, d); check("R1 det thr", d, 15);
    rd(8'h21, d); check("R1 corr thr", d, 15);

    // R12 register readback
    wr(8'h20, 8'h05); wr(8'h21, 8'hFF); wr(8'h08, 8'hFF);
    rd(8'h20, d); check("R12 det thr", d, 5);
    rd(8'h21, d); check("R12 corr thr", d, 255);
    rd(8'h08, d); check("R12 ctrl bit2 only", d, 4);
    rd(8'h55, d); check("R12 unmapped", d, 0);
    wr(8'h08, 8'h00);

    // R6 lock acquisition
    lock_i = 1'b1; tick(1);
    check("R6 lock_o rises", int'(lock_o), 1);

    // R7 freeze while unlocked, R6 clear on relock
    det_burst(2, 6); corr_burst(2, 1);
    lock_i = 1'b0; tick(1);
    check("R7 lock_o falls", int'(lock_o), 0);
    det_burst(3, 6);
    rd(8'h10, d); check("R7 frozen det", d, 2);
    lock_i = 1'b1; tick(1);
    check("R6 relock", int'(lock_o), 1);
    rd(8'h12, d); check("R6 corr cleared", d, 0);
    tick(20);

    // R2 R4 R5 detected counter sweep, threshold 5
    for (int n = 0; n <= 8; n++) begin
      det_burst(n, 6); tick(2);
      check("R4 det alarm", int'(alarm_n), (n <= 5) ? 1 : 0);
      rd(8'h10, d); check("R2 det count", d, n);
      tick(1);
      check("R5 release", int'(alarm_n), 1);
    end

    // corrected counter sweep, threshold 3
    wr(8'h20, 8'hFF); wr(8'h21, 8'h03);
    for (int n = 0; n <= 5; n++) begin
      corr_burst(n, 1); tick(2);
      check("R4 corr alarm", int'(alarm_n), (n <= 3) ? 1 : 0);
      rd(8'h12, d); check("R2 corr count", d, n);
      tick(1);
      check("R5 release corr", int'(alarm_n), 1);
    end

    // R3 strobe colliding with read
    corr_burst(3, 1);
    reg_addr = 8'h12; reg_rd = 1'b1; corr_err = 1'b1;
    tick(1);
    reg_rd = 1'b0; corr_err = 1'b0;
    check("R3 read value", int'(reg_rdata), 3);
    rd(8'h12, d); check("R3 kept strobe", d, 1);

    // R2 saturation, R4 threshold 255 never alarms
    wr(8'h21, 8'hFF);
    det_burst(260, 6); tick(2);
    check("R4 thr 255 no alarm", int'(alarm_n), 1);
    rd(8'h10, d); check("R2 det saturates", d, 255);
    corr_burst(300, 1);
    rd(8'h12, d); check("R2 corr saturates", d, 255);
    tick(20);

    // R10 density loss, four in a row
    det_burst(3, 1);
    check("R10 three keep lock", int'(lock_o), 1);
    det_burst(1, 1);
    check("R10 lock lost", int'(lock_o), 0);
    check("R10 relock req", int'(relock_o), 1);
    rd(8'h10, d); check("R10 trigger counted", d, 4);
    det_burst(2, 6);
    rd(8'h10, d); check("R7 frozen in relock", d, 0);

    // R11 relock handshake
    tick(5);
    check("R11 waits lock_o", int'(lock_o), 0);
    check("R11 waits relock", int'(relock_o), 1);
    lock_i = 1'b0; tick(1);
    check("R11 relock drops", int'(relock_o), 0);
    lock_i = 1'b1; tick(1);
    check("R11 relocked", int'(lock_o), 1);

    // R10 spacing 5 trips, spacing 6 does not
    det_burst(3, 5);
    check("R10 gap5 three", int'(lock_o), 1);
    det_burst(1, 5);
    check("R10 gap5 fourth", int'(lock_o), 0);
    lock_i = 1'b0; tick(1); lock_i = 1'b1; tick(1);
    det_burst(8, 6);
    check("R10 gap6 holds", int'(lock_o), 1);
    rd(8'h10, d);
    tick(2);

    // R8 test-pattern mode
    det_burst(2, 6);
    prbs_mode = 1'b1; tick(2);
    rd(8'h10, d); check("R8 det held zero", d, 0);
    check("R8 no alarm on entry", int'(alarm_n), 1);
    prbs_err = 1'b1; tick(1); prbs_err = 1'b0; tick(1);
    check("R8 first error alarm", int'(alarm_n), 0);
    prbs_burst(2, 1);
    det_burst(1, 1); corr_burst(1, 1);
    rd(8'h10, d); check("R8 det ignores strobe", d, 0);
    rd(8'h12, d); check("R8 corr ignores strobe", d, 0);
    rd(8'h13, d); check("R8 prbs count", d, 3);
    tick(1);
    check("R8 release on read", int'(alarm_n), 1);

    // R9 self-clear idle in test mode
    wr(8'h08, 8'h04);
    prbs_burst(1, 1);
    tick(ACLR + 20);
    check("R9 no clear in test mode", int'(alarm_n), 0);
    rd(8'h13, d); check("R9 prbs kept", d, 1);
    tick(1);
    prbs_mode = 1'b0; tick(2);

    // R9 self-clear timing
    wr(8'h21, 8'h00);
    corr_burst(1, 1);
    tick(1);
    low = 0;
    while (!alarm_n && low < 1000) begin
      low++; tick(1);
    end
    check("R9 alarm low cycles", low, ACLR + 1);
    rd(8'h12, d); check("R9 counter cleared", d, 0);

    // R9 disabled
    wr(8'h08, 8'h00);
    corr_burst(1, 1);
    tick(ACLR + 20);
    check("R9 disabled keeps alarm", int'(alarm_n), 0);
    rd(8'h12, d); check("R9 disabled count", d, 1);
    tick(1);
    check("R5 release after read", int'(alarm_n), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule